// File: doc/BRIEF.md
# Mirrored Coin Counter Coil Latch

This block holds the single bit that energises the coil of an electromechanical coin meter in an arcade-style machine built around an 8-bit CPU bus. Game software makes the timing of each count: it drives the bit high, waits, then drives it low, and every 1-to-0 pair advances the meter by one. The block only stores the level and presents it on the coil output. A narrow decode (three top address bits plus one low bit) makes the latch appear at many mirrored addresses. Because the bus is shared, a plain read of any of those addresses also loads the latch, with bit 0 taken from whatever value is floating on the data bus at that moment.

A monitor sits alongside the latch for verification and bring-up. It counts completed high-then-low pulses on the coil and raises sticky flags when software makes a high or low interval shorter than a parameterised number of clock cycles. Both an asynchronous power-on reset and a synchronous watchdog clear force the coil off and restart the monitor.

Top module: `coin_meter_latch`

## Requirements
- R1: The latch is selected when address bits [15:13] equal 3'b010 and address bit 5 equals 1; all other bits are ignored, so 0x4020, 0x4ABC and 0x5FFF all select it, while 0x401F, 0x6020 and 0x2020 do not.
- R2: A write strobe at a selected address loads data bit 0 into the latch; the new level appears on `coil_drive` after the clock edge that samples the strobe.
- R3: `coil_drive` is the latch bit with no stretching or timing of its own; it holds its level for any number of idle cycles.
- R4: A read strobe at a selected address loads bit 0 of `bus_float` into the latch; when read and write strobes are both high, the write data wins.
- R5: `arst_n` low (asynchronous, released through a two-flop synchroniser) and `wdog_clr` high (synchronous) both clear the latch to 0, the pulse tally to 0 and both timing flags to 0.
- R6: An access at an address that is not selected, or a cycle with neither strobe high, leaves `coil_drive` unchanged.
- R7: `pulse_tally` increments by one, wrapping at its width, on each 1-to-0 change of the coil level, one cycle after the change shows on `coil_drive`.
- R8: `short_high` is set, and stays set until a clear, when a high interval (clock edges at which the coil was sampled high) ends with fewer than MIN_HIGH cycles.
- R9: `short_low` is set, and stays set until a clear, when a low interval that began with a fall ends in a rise with fewer than MIN_LOW cycles; the low time before the first fall after a clear is not judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wdog_clr | input | 1 | Synchronous clear from the watchdog |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| bus_float | input | 8 | Value currently floating on the data bus |
| coil_drive | output | 1 | Coin meter coil level |
| pulse_tally | output | 8 | Completed high-then-low pulses, wrapping |
| short_high | output | 1 | Sticky: a high interval was too short |
| short_low | output | 1 | Sticky: a low interval was too short |

## Verification
A wrong latch bit shows on `coil_drive` one edge after the access that caused it, and it stays wrong until software touches the latch again. A fault in the decode is invisible until an access lands on an address where the wrong decode and the right one differ, so the stimulus favours near-miss addresses with a single bit off the pattern. Monitor faults lag by one further edge: a missed or extra fall moves `pulse_tally` for good, and a wrong interval comparison sets a sticky flag that never clears without a reset.

// File: rtl/coin_meter_pkg.sv
package coin_meter_pkg;
  // Kind of bus access seen by the latch in one cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/coin_rst_sync.sv
module coin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/coin_addr_decode.sv
module coin_addr_decode
  import coin_meter_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          TOP_BITS = 3,
  parameter logic [TOP_BITS-1:0] TOP_CODE = 3'b010,
  parameter int          KEY_BIT  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output acc_e              kind
);
  localparam int TOP_LSB = ADDR_W - TOP_BITS;

  logic hit;

  always_comb begin
    hit  = (addr[ADDR_W-1:TOP_LSB] == TOP_CODE) && addr[KEY_BIT];
    kind = ACC_NONE;
    if (hit && wr)      kind = ACC_WR;
    else if (hit && rd) kind = ACC_RD;
  end
endmodule

// File: rtl/coin_level_latch.sv
module coin_level_latch
  import coin_meter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  acc_e kind,
  input  logic wbit,
  input  logic fbit,
  output logic level
);
  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (clr)                 level_d = 1'b0;
    else if (kind == ACC_WR) level_d = wbit;
    else if (kind == ACC_RD) level_d = fbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign level = level_q;

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && kind == ACC_WR) |=> (level_q == $past(wbit)));
  // R4
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && kind == ACC_RD) |=> (level_q == $past(fbit)));
  // R6
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && kind == ACC_NONE) |=> $stable(level_q));
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !level_q);
endmodule

// File: rtl/coin_pulse_monitor.sv
module coin_pulse_monitor #(
  parameter int CNT_W    = 8,
  parameter int MIN_HIGH = 16,
  parameter int MIN_LOW  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             level,
  output logic [CNT_W-1:0] tally,
  output logic             short_high,
  output logic             short_low
);
  localparam int RUN_MAX = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] HI_MIN  = RUN_W'(MIN_HIGH);
  localparam logic [RUN_W-1:0] LO_MIN  = RUN_W'(MIN_LOW);

  logic             prev_q, prev_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] tally_q, tally_d;
  logic             sh_q, sh_d, sl_q, sl_d;
  logic             fell, rose;

  always_comb begin
    fell    = prev_q & ~level;
    rose    = ~prev_q & level;
    prev_d  = level;
    if (fell || rose)        run_d = RUN_W'(1);
    else if (run_q == RUN_TOP) run_d = run_q;
    else                     run_d = run_q + RUN_W'(1);
    armed_d = armed_q | fell;
    tally_d = fell ? tally_q + CNT_W'(1) : tally_q;
    sh_d    = sh_q | (fell && (run_q < HI_MIN));
    sl_d    = sl_q | (rose && armed_q && (run_q < LO_MIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b0;
      tally_q <= '0;
      sh_q    <= 1'b0;
      sl_q    <= 1'b0;
    end else if (clr) begin
      prev_q  <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b0;
      tally_q <= '0;
      sh_q    <= 1'b0;
      sl_q    <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      tally_q <= tally_d;
      sh_q    <= sh_d;
      sl_q    <= sl_d;
    end
  end

  assign tally      = tally_q;
  assign short_high = sh_q;
  assign short_low  = sl_q;

  // R7
  tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && prev_q && !level) |=> (tally_q == $past(tally_q) + CNT_W'(1)));
  // R7
  tally_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(prev_q && !level)) |=> $stable(tally_q));
  // R8
  high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sh_q) |=> sh_q);
  // R9
  low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sl_q) |=> sl_q);
endmodule

// File: rtl/coin_meter_latch.sv
module coin_meter_latch
  import coin_meter_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int MIN_HIGH = 16,
  parameter int MIN_LOW  = 22
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wdog_clr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] bus_float,
  output logic              coil_drive,
  output logic [CNT_W-1:0]  pulse_tally,
  output logic              short_high,
  output logic              short_low
);
  logic srst_n;
  acc_e kind;
  logic level;

  coin_rst_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  coin_addr_decode #(
    .ADDR_W   (ADDR_W),
    .TOP_BITS (3),
    .TOP_CODE (3'b010),
    .KEY_BIT  (5)
  ) u_dec (
    .addr (cpu_addr),
    .rd   (cpu_rd),
    .wr   (cpu_wr),
    .kind (kind)
  );

  coin_level_latch u_latch (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (wdog_clr),
    .kind  (kind),
    .wbit  (cpu_data[0]),
    .fbit  (bus_float[0]),
    .level (level)
  );

  coin_pulse_monitor #(
    .CNT_W    (CNT_W),
    .MIN_HIGH (MIN_HIGH),
    .MIN_LOW  (MIN_LOW)
  ) u_mon (
    .clk        (clk),
    .rst_n      (srst_n),
    .clr        (wdog_clr),
    .level      (level),
    .tally      (pulse_tally),
    .short_high (short_high),
    .short_low  (short_low)
  );

  assign coil_drive = level;
endmodule

// File: tb/coin_meter_latch_test.sv
module coin_meter_latch_test;
  localparam int MINH    = 16;
  localparam int MINL    = 22;
  localparam int RUN_MAX = (MINH > MINL) ? MINH : MINL;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        wdog_clr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  bus_float = '0;
  logic        coil_drive;
  logic [7:0]  pulse_tally;
  logic        short_high;
  logic        short_low;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench models
  bit       e_level = 0;
  bit       m_prev = 0;
  int       m_run = 0;
  bit       m_armed = 0;
  bit [7:0] m_tally = 0;
  bit       m_sh = 0;
  bit       m_sl = 0;

  always #10 clk = ~clk;

  coin_meter_latch uut (
    .clk(clk), .arst_n(arst_n), .wdog_clr(wdog_clr),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .bus_float(bus_float), .coil_drive(coil_drive), .pulse_tally(pulse_tally),
    .short_high(short_high), .short_low(short_low)
  );

  function automatic bit sel_hit(input logic [15:0] a);
    return (a[15:13] == 3'b010) && a[5];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_level = 0; m_prev = 0; m_run = 0; m_armed = 0;
    m_tally = 0; m_sh = 0; m_sl = 0;
  endtask

  task automatic model_monitor(input bit s);
    if (s != m_prev) begin
      if (m_prev && !s) begin
        m_tally = m_tally + 8'd1;
        if (m_run < MINH) m_sh = 1;
        m_armed = 1;
      end else if (m_armed && m_run < MINL) begin
        m_sl = 1;
      end
      m_run = 1;
    end else if (m_run < RUN_MAX) begin
      m_run++;
    end
    m_prev = s;
  endtask

  task automatic check_all(input string req);
    check({req, " coil"},  int'(coil_drive),  int'(e_level));
    check({req, " tally"}, int'(pulse_tally), int'(m_tally));
    check({req, " shigh"}, int'(short_high),  int'(m_sh));
    check({req, " slow"},  int'(short_low),   int'(m_sl));
  endtask

  // one bus cycle: drive at negedge, edge, update models at next negedge
  task automatic step(input logic [15:0] a, input bit rd, input bit wr,
                      input logic [7:0] d, input logic [7:0] f, input bit clr,
                      input string req);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_data = d; bus_float = f;
    wdog_clr = clr;
    @(posedge clk);
    @(negedge clk);
    if (clr) begin
      model_reset();
    end else begin
      model_monitor(e_level);
      if (sel_hit(a) && wr)      e_level = d[0];
      else if (sel_hit(a) && rd) e_level = f[0];
    end
    check_all(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(16'h0000, 0, 0, 8'h00, 8'h00, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R5 reset state");
    arst_n = 1'b1;
    idle(4, "R5 after release");

    // R1 R2: write 1 at base mirror
    step(16'h4020, 0, 1, 8'h01, 8'h00, 0, "R2 write one");
    // R3: holds high
    idle(20, "R3 hold high");
    // R1: top mirror write 0, long high so no flag (R7)
    step(16'h5FFF, 0, 1, 8'hFE, 8'h00, 0, "R1 top mirror");
    idle(1, "R7 tally after fall");
    // R6: misses and no strobe
    step(16'h401F, 0, 1, 8'h01, 8'h01, 0, "R6 bit5 clear");
    step(16'h6020, 0, 1, 8'h01, 8'h01, 0, "R6 top code 011");
    step(16'h2020, 1, 0, 8'h01, 8'h01, 0, "R6 top code 001");
    step(16'h4020, 0, 0, 8'h01, 8'h01, 0, "R6 no strobe");
    idle(30, "R3 hold low");
    // R1: inner mirror write 1
    step(16'h4ABC, 0, 1, 8'h03, 8'h00, 0, "R1 inner mirror");
    idle(20, "R3 hold high 2");
    // R4: read loads float bit 0
    step(16'h4020, 1, 0, 8'hFF, 8'h40, 0, "R4 read float zero");
    idle(25, "R3 hold low 2");
    // R4: read and write together, write wins
    step(16'h4020, 1, 1, 8'h01, 8'h00, 0, "R4 write priority");
    idle(2, "R8 short high pending");
    step(16'h4020, 0, 1, 8'h00, 8'h00, 0, "R8 short high end");
    idle(1, "R8 short high flag");
    idle(3, "R9 short low pending");
    step(16'h4020, 1, 0, 8'h00, 8'h41, 0, "R9 read float one");
    idle(1, "R9 short low flag");
    // R5: watchdog clear mid high
    step(16'h0000, 0, 0, 8'h00, 8'h00, 1, "R5 watchdog clear");
    idle(3, "R5 after clear");
    // R9: low before first fall not judged
    step(16'h4020, 0, 1, 8'h01, 8'h00, 0, "R9 first rise unjudged");
    idle(20, "R3 hold high 3");
    step(16'h4020, 0, 1, 8'h00, 8'h00, 0, "R7 second fall");
    idle(25, "R9 long low");
    step(16'h4020, 0, 1, 8'h01, 8'h00, 0, "R9 long low rise");
    // R5: asynchronous reset mid run
    @(negedge clk);
    arst_n = 1'b0;
    #3;
    model_reset();
    check({"R5 async coil"}, int'(coil_drive), 0);
    @(negedge clk);
    check_all("R5 async reset");
    arst_n = 1'b1;
    idle(4, "R5 async release");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      bit rd, wr, clr;
      int r;
      r = int'($urandom % 100);
      a = 16'($urandom);
      rd = 0; wr = 0; clr = 0;
      if (r < 55) begin
        rd = 0; wr = 0;
      end else begin
        if (($urandom % 100) < 60) begin
          a[15:13] = 3'b010;
          a[5] = 1'b1;
        end else if (($urandom % 2) == 1) begin
          a[15:13] = 3'b010;
          a[5] = 1'b0;
        end
        rd = 1'($urandom);
        wr = 1'($urandom);
      end
      if (r == 99 && ($urandom % 4) == 0) clr = 1;
      step(a, rd, wr, 8'($urandom), 8'($urandom), clr, "R1 R2 R4 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule